// File: doc/BRIEF.md
# Multicycle Unsigned 32-by-16 Divider

This block carries out the word-size unsigned extended-divide operation of a 16-bit CPU datapath. A 32-bit dividend, taken from an extended register, is divided by a 16-bit divisor, taken from any 16-bit register half. The 16-bit quotient goes into the low half of the 32-bit result and the 16-bit remainder into the high half. Only two condition flags are rewritten, and both come from the divisor: the sign flag copies the divisor's top bit and the zero flag reports a zero divisor. Every other flag bit passes through unchanged.

The datapath is a restoring shift-subtract loop that produces one quotient bit per clock. Idle states pad it so that the operation always takes the same number of states, including for a zero divisor. The result is undefined for a zero divisor, or when the dividend's upper half is not below the divisor, because the quotient then needs more than 16 bits. The flags are still correct in both cases. A small decoder splits the two-byte instruction word into the source-half and destination-register indices for the register file.

The request side is valid/ready. `in_ready` is high exactly while the unit is idle, and a request transfers on a clock edge where `in_valid` and `in_ready` are both high. While busy, the unit holds `in_ready` low and ignores `in_valid`, so the upstream stage must hold its request until ready returns. The response side has no back-pressure. `done` is a one-cycle pulse, and the consumer must take `out_result` and `out_flags` in that cycle, although both also hold their values until the next `done`.

Top module: `wdiv_unit`

## Requirements
- R1: While `busy` is high, `in_ready` is low and `in_valid` has no effect: the running operation's result, flags and timing are unchanged, and no second operation starts.
- R2: `done` is high for exactly one cycle. That cycle is the 22nd clock cycle after the accepting edge, counting the cycle that follows the accepting edge as the first.
- R3: `busy` is high from the cycle after the accepting edge through the `done` cycle. In the cycle after `done`, `busy` is low and `in_ready` is high.
- R4: When the divisor is nonzero and dividend[31:16] is below the divisor, `out_result[15:0]` in the `done` cycle is the quotient and `out_result[31:16]` is the remainder.
- R5: Flag bit 3 (N) of `out_flags` equals bit 15 of the divisor.
- R6: Flag bit 2 (Z) of `out_flags` is 1 exactly when the divisor is zero. A zero divisor keeps the latency of R2.
- R7: All flag bits other than bits 3 and 2 (H at bit 5, V at bit 1, C at bit 0, and bits 7, 6 and 4) equal `in_flags` as sampled at the accepting edge.
- R8: Decode is combinational. `dec_src` is `in_opcode[7:4]` and `dec_dst` is `in_opcode[2:0]`. `dec_legal` is 1 exactly when `in_opcode[15:8]` is 0x53 and `in_opcode[3]` is 0.
- R9: After reset, `busy` and `done` are 0, `in_ready` is 1, and `out_result` and `out_flags` are 0. The outputs change only on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit idle and able to accept a request |
| in_opcode | input | 16 | Two-byte instruction word, first byte in bits 15:8 |
| in_dividend | input | 32 | Unsigned dividend |
| in_divisor | input | 16 | Unsigned divisor |
| in_flags | input | 8 | Incoming condition flags |
| dec_src | output | 4 | Source register-half index |
| dec_dst | output | 3 | Destination extended-register index |
| dec_legal | output | 1 | Instruction word matches the divide encoding |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| out_result | output | 32 | Remainder in bits 31:16, quotient in bits 15:0 |
| out_flags | output | 8 | Updated condition flags |

## Verification
The remainder-bound assertion in the datapath assumes that each operation starts with dividend[31:16] below a nonzero divisor. It only fires when that condition holds at the start, so zero or overflowing operands fall outside it and cause no failure. The directed quotient and remainder checks use only dividends whose upper half is below the divisor. The zero-divisor case checks only the flags and the timing. The handshake assertions assume that `in_valid` may be driven at any time. The bench raises it on purpose during busy cycles to show that it has no effect.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
  localparam int FLAG_W    = 8;
  localparam int FLAG_SIGN = 3;
  localparam int FLAG_ZERO = 2;
  localparam logic [7:0] DIV_OPBYTE = 8'h53;

  typedef struct packed {
    logic [3:0] src;
    logic [2:0] dst;
    logic       legal;
  } dec_t;
endpackage

// File: rtl/wdiv_decode.sv
module wdiv_decode
  import wdiv_pkg::*;
(
  input  logic [15:0] opcode,
  output dec_t        dec
);
  always_comb begin
    dec.src   = opcode[7:4];
    dec.dst   = opcode[2:0];
    dec.legal = (opcode[15:8] == DIV_OPBYTE) && !opcode[3];
  end

  always_comb begin
    if ((opcode[15:8] == DIV_OPBYTE) && (opcode[3] == 1'b0))
      AST_LEGAL_CODE: assert (dec.legal); // R8
  end
endmodule

// File: rtl/wdiv_seq.sv
module wdiv_seq #(
  parameter int STATES = 22,
  parameter int STEPS  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic busy,
  output logic step,
  output logic finish,
  output logic done
);
  localparam int CW = $clog2(STATES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= CW'(1);
      end else if (busy) begin
        if (done) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(STATES - 1)) done <= 1'b1;
        end
      end
    end
  end

  assign step   = busy && (cnt <= CW'(STEPS));
  assign finish = busy && (cnt == CW'(STATES - 1));

  AST_STEP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !done); // R2
endmodule

// File: rtl/wdiv_core.sv
module wdiv_core #(
  parameter int QW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [2*QW-1:0] dividend,
  input  logic [QW-1:0]   divisor,
  output logic [QW-1:0]   quot,
  output logic [QW-1:0]   rem
);
  logic [QW-1:0] rem_q, lo_q, dv_q;
  logic [QW:0]   trial, diff;
  logic          ge;

  always_comb begin
    trial = {rem_q, lo_q[QW-1]};
    ge    = trial >= {1'b0, dv_q};
    diff  = trial - {1'b0, dv_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      lo_q  <= '0;
      dv_q  <= '0;
    end else if (load) begin
      rem_q <= dividend[2*QW-1:QW];
      lo_q  <= dividend[QW-1:0];
      dv_q  <= divisor;
    end else if (step) begin
      rem_q <= ge ? diff[QW-1:0] : trial[QW-1:0];
      lo_q  <= {lo_q[QW-2:0], ge};
    end
  end

  assign quot = lo_q;
  assign rem  = rem_q;

  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && dv_q != '0 && rem_q < dv_q) |=> (rem_q < dv_q)); // R4
endmodule

// File: rtl/wdiv_unit.sv
module wdiv_unit
  import wdiv_pkg::*;
#(
  parameter int QW     = 16,
  parameter int STATES = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_opcode,
  input  logic [2*QW-1:0]   in_dividend,
  input  logic [QW-1:0]     in_divisor,
  input  logic [FLAG_W-1:0] in_flags,
  output logic [3:0]        dec_src,
  output logic [2:0]        dec_dst,
  output logic              dec_legal,
  output logic              busy,
  output logic              done,
  output logic [2*QW-1:0]   out_result,
  output logic [FLAG_W-1:0] out_flags
);
  localparam int CW = $clog2(STATES + 1);

  dec_t          dec;
  logic          accept, step, finish;
  logic [QW-1:0] quot, rem;
  logic [FLAG_W-1:0] flag_hold;
  logic          sign_hold, zero_hold;

  wdiv_decode u_dec (.opcode(in_opcode), .dec(dec));
  assign dec_src   = dec.src;
  assign dec_dst   = dec.dst;
  assign dec_legal = dec.legal;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  wdiv_seq #(.STATES(STATES), .STEPS(QW)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .busy(busy), .step(step), .finish(finish), .done(done));

  wdiv_core #(.QW(QW)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
    .dividend(in_dividend), .divisor(in_divisor),
    .quot(quot), .rem(rem));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_hold <= '0;
      sign_hold <= 1'b0;
      zero_hold <= 1'b0;
    end else if (accept) begin
      flag_hold <= in_flags;
      sign_hold <= in_divisor[QW-1];
      zero_hold <= (in_divisor == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_result <= '0;
      out_flags  <= '0;
    end else if (finish) begin
      out_result <= {rem, quot};
      out_flags  <= flag_hold;
      out_flags[FLAG_SIGN] <= sign_hold;
      out_flags[FLAG_ZERO] <= zero_hold;
    end
  end

  // independent latency counter for the checks below
  logic [CW-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n)          lat_q <= '0;
    else if (accept)     lat_q <= CW'(1);
    else if (lat_q != '0 && lat_q < CW'(STATES)) lat_q <= lat_q + CW'(1);
    else                 lat_q <= '0;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == CW'(STATES))); // R2
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (in_ready && !busy)); // R3
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy); // R3
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(out_result) && $stable(out_flags))); // R9
endmodule

// File: tb/tb_wdiv_unit.sv
module tb_wdiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_opcode = 16'h5300;
  logic [31:0] in_dividend = '0;
  logic [15:0] in_divisor = '0;
  logic [7:0]  in_flags = '0;
  logic [3:0]  dec_src;
  logic [2:0]  dec_dst;
  logic        dec_legal;
  logic        busy, done;
  logic [31:0] out_result;
  logic [7:0]  out_flags;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  wdiv_unit dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_flags(input logic [7:0] f, input logic [15:0] d);
    logic [7:0] r;
    r = f;
    r[3] = d[15];
    r[2] = (d == 16'h0);
    return r;
  endfunction

  // run one operation; optionally pulse in_valid with junk while busy
  task automatic run_op(input logic [31:0] dvd, input logic [15:0] dvs, input logic [7:0] fl,
                        input bit check_vals, input bit poke);
    int n;
    logic [31:0] exp_r;
    @(negedge clk);
    in_valid = 1'b1; in_dividend = dvd; in_divisor = dvs; in_flags = fl;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n = 1;
    chk(busy && !in_ready, "R3 busy after accept", {30'b0, busy, in_ready}, 32'h2);
    while (!done && n < 40) begin
      if (poke && n == 5) begin
        in_valid = 1'b1; in_dividend = 32'h0000_0001; in_divisor = 16'h0003; in_flags = ~fl;
      end
      if (poke && n == 8) in_valid = 1'b0;
      if (!done && n > 1) chk(busy, "R3 busy held", {31'b0, busy}, 32'h1);
      @(negedge clk);
      n++;
    end
    in_valid = 1'b0;
    chk(n == 22, "R2 latency", n, 32'd22);
    chk(out_flags == exp_flags(fl, dvs), "R5 R6 R7 flags", {24'b0, out_flags}, {24'b0, exp_flags(fl, dvs)});
    if (check_vals) begin
      exp_r = {16'(dvd % {16'b0, dvs}), 16'(dvd / {16'b0, dvs})};
      chk(out_result == exp_r, "R4 quotient/remainder", out_result, exp_r);
    end
    exp_r = out_result;
    @(negedge clk);
    chk(!done && !busy && in_ready, "R3 idle after done", {29'b0, done, busy, in_ready}, 32'h1);
    chk(out_result == exp_r, "R9 result held", out_result, exp_r);
  endtask

  task automatic t_reset();
    chk(!busy && !done && in_ready, "R9 reset control", {29'b0, busy, done, in_ready}, 32'h1);
    chk(out_result == 0 && out_flags == 0, "R9 reset outputs", out_result, 32'h0);
  endtask

  task automatic t_basic();
    run_op(32'h0001_86A0, 16'h0007, 8'h00, 1'b1, 1'b0);
    run_op(32'hFFFE_FFFF, 16'hFFFF, 8'h23, 1'b1, 1'b0);
    run_op(32'h1234_5678, 16'h8000, 8'hD1, 1'b1, 1'b0);
    run_op(32'h0000_0005, 16'h0009, 8'hFF, 1'b1, 1'b0);
    run_op(32'h0000_0000, 16'h0001, 8'h2A, 1'b1, 1'b0);
  endtask

  task automatic t_zero_div();
    run_op(32'h1234_5678, 16'h0000, 8'hE3, 1'b0, 1'b0); // R6
  endtask

  task automatic t_busy_ignore();
    logic [31:0] r;
    run_op(32'h00AB_CDEF, 16'h1234, 8'h21, 1'b1, 1'b1); // R1
    r = out_result;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (busy || done) begin
        chk(1'b0, "R1 no second op", {30'b0, busy, done}, 32'h0);
        break;
      end
    end
    chk(out_result == r, "R1 result untouched", out_result, r);
  endtask

  task automatic t_decode();
    @(negedge clk); in_opcode = 16'h53A5; #1;
    chk(dec_src == 4'hA && dec_dst == 3'd5 && dec_legal, "R8 decode legal",
        {24'b0, dec_src, dec_legal, dec_dst}, 32'hAD);
    @(negedge clk); in_opcode = 16'h53FB; #1;
    chk(dec_src == 4'hF && dec_dst == 3'd3 && !dec_legal, "R8 bit3 set",
        {24'b0, dec_src, dec_legal, dec_dst}, 32'hF3);
    @(negedge clk); in_opcode = 16'h5203; #1;
    chk(!dec_legal, "R8 wrong first byte", {31'b0, dec_legal}, 32'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    chk(1'b0, "watchdog", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_basic();
    t_zero_div();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule